// File: doc/BRIEF.md
# Shared Expander Product-Term Fabric

This block is the combinational evaluation fabric of one logic array block. It has a pool of expander terms that every macrocell in the block can use. The inputs are the dedicated inputs, the signals routed in from the global interconnect, the feedbacks from the macrocells and the feedbacks from the I/O pins. These are joined into one array-input vector. Each expander forms the inverted AND of the literals chosen for it. A literal is any array input, or the output of any lower-numbered expander, taken in true or complement form. Because an expander may use only lower-numbered expanders, it can cascade into a later one without ever closing a loop.

Every macrocell has a fixed set of product terms. A few of them are summed to form the logic function. One more term sets the output polarity, and four more drive the macrocell's preset, clear, clock and output-enable controls. Each product term ANDs the array-input and expander literals chosen for it. Any expander may feed any term of any macrocell, and it may feed many of them at the same time. All selections come from static configuration vectors. There is no storage in the block, so the outputs follow the inputs in the same cycle.

Top module: `shared_expander_fabric`

## Requirements
- R1: Expander e outputs the NAND of its selected literals. An expander with no literal selected outputs 1. Array literal i of expander e is selected in true form by exp_sel_t_i bit e*N_ARR+i and in complement form by exp_sel_c_i at the same bit.
- R2: Expander e may use expander j in true form (exp_chain_t_i bit e*N_EXP+j) or in complement form (exp_chain_c_i, same bit) only when j < e. Chain select bits with j >= e have no effect.
- R3: A product term is the AND of its selected literals. A product term with no literal selected is 0.
- R4: A macrocell's logic output is the OR of its N_SUM sum terms, XORed with its polarity term.
- R5: The preset, clear, clock and output-enable outputs of a macrocell each equal their own dedicated product term.
- R6: One expander output may be used at the same time by every macrocell and by several terms of one macrocell, and each of those uses sees the same value.
- R7: A term or expander that selects the same literal in both true and complement form has a product of 0.
- R8: Array input bits are ordered as follows: dedicated inputs from bit 0, then interconnect inputs, then macrocell feedbacks, then I/O pin feedbacks.
- R9: Term slot k of macrocell m takes its array selects at bits (m*N_PT+k)*N_ARR+i and its expander selects at bits (m*N_PT+k)*N_EXP+j. The slots are numbered as follows: slots 0 to N_SUM-1 are the sum terms, then polarity, preset, clear, clock and output enable, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ded_i | input | N_DED | Dedicated inputs |
| pia_i | input | N_PIA | Signals from the global interconnect |
| mc_fb_i | input | N_MC | Macrocell feedbacks |
| io_fb_i | input | N_IO | I/O pin feedbacks |
| exp_sel_t_i | input | N_EXP*N_ARR | Expander array selects, true form |
| exp_sel_c_i | input | N_EXP*N_ARR | Expander array selects, complement form |
| exp_chain_t_i | input | N_EXP*N_EXP | Expander-to-expander selects, true form |
| exp_chain_c_i | input | N_EXP*N_EXP | Expander-to-expander selects, complement form |
| pt_sel_t_i | input | N_MC*N_PT*N_ARR | Term array selects, true form |
| pt_sel_c_i | input | N_MC*N_PT*N_ARR | Term array selects, complement form |
| pt_exp_t_i | input | N_MC*N_PT*N_EXP | Term expander selects, true form |
| pt_exp_c_i | input | N_MC*N_PT*N_EXP | Term expander selects, complement form |
| mc_fn_o | output | N_MC | Logic output of each macrocell |
| mc_pre_o | output | N_MC | Preset term of each macrocell |
| mc_clr_o | output | N_MC | Clear term of each macrocell |
| mc_clk_o | output | N_MC | Clock term of each macrocell |
| mc_oe_o | output | N_MC | Output-enable term of each macrocell |

## Verification
The checks are immediate assertions, evaluated whenever the fabric settles. They assume that the configuration is static while the data inputs move. They also assume that an input counts as selected only through the select bits set out in R1, R2 and R9. The bench keeps to this: it changes the configuration only between comparisons and holds it steady while the data inputs change. Random configurations set each select bit sparsely, so that many terms remain non-empty and non-contradictory. Directed steps then cover the empty, contradictory, ignored-chain and fully shared cases one at a time.

// File: rtl/sxf_pkg.sv
package sxf_pkg;

   // Secondary slots that follow the N_SUM sum terms of each macrocell
   localparam int SLOT_POL = 0;
   localparam int SLOT_PRE = 1;
   localparam int SLOT_CLR = 2;
   localparam int SLOT_CLK = 3;
   localparam int SLOT_OE  = 4;
   localparam int N_SEC    = 5;

   typedef struct packed {
      logic oe;
      logic clk;
      logic clr;
      logic pre;
      logic fn;
   } mc_out_t;

endpackage

// File: rtl/sxf_product_term.sv
module sxf_product_term #(
   parameter int W_ARR = 4,
   parameter int W_EXP = 4
) (
   input  logic [W_ARR-1:0] arr_i,
   input  logic [W_EXP-1:0] exp_i,
   input  logic [W_ARR-1:0] sel_at_i,
   input  logic [W_ARR-1:0] sel_ac_i,
   input  logic [W_EXP-1:0] sel_et_i,
   input  logic [W_EXP-1:0] sel_ec_i,
   output logic             term_o
);

   logic used;
   logic hit_arr;
   logic hit_exp;

   always_comb begin
      used    = (|sel_at_i) | (|sel_ac_i) | (|sel_et_i) | (|sel_ec_i);
      hit_arr = (&(arr_i | ~sel_at_i)) & (&(~arr_i | ~sel_ac_i));
      hit_exp = (&(exp_i | ~sel_et_i)) & (&(~exp_i | ~sel_ec_i));
      term_o  = used & hit_arr & hit_exp;
   end

endmodule

// File: rtl/sxf_expander_pool.sv
module sxf_expander_pool #(
   parameter int N_ARR = 4,
   parameter int N_EXP = 4
) (
   input  logic [N_ARR-1:0]       arr_i,
   input  logic [N_EXP*N_ARR-1:0] sel_t_i,
   input  logic [N_EXP*N_ARR-1:0] sel_c_i,
   input  logic [N_EXP*N_EXP-1:0] chain_t_i,
   input  logic [N_EXP*N_EXP-1:0] chain_c_i,
   output logic [N_EXP-1:0]       exp_o
);

   for (genvar e = 0; e < N_EXP; e++) begin : g_e
      // Only expanders below e are visible to expander e
      localparam logic [N_EXP-1:0] LOW = (e == 0) ? '0 : ({N_EXP{1'b1}} >> (N_EXP - e));
      logic [N_EXP-1:0] prev;
      logic [N_EXP-1:0] nxt;
      logic             term;

      if (e == 0) begin : g_first
         assign prev = '0;
      end else begin : g_rest
         assign prev = g_e[e-1].nxt;
      end

      sxf_product_term #(.W_ARR(N_ARR), .W_EXP(N_EXP)) u_term (
         .arr_i    (arr_i),
         .exp_i    (prev),
         .sel_at_i (sel_t_i[e*N_ARR +: N_ARR]),
         .sel_ac_i (sel_c_i[e*N_ARR +: N_ARR]),
         .sel_et_i (chain_t_i[e*N_EXP +: N_EXP] & LOW),
         .sel_ec_i (chain_c_i[e*N_EXP +: N_EXP] & LOW),
         .term_o   (term)
      );

      assign nxt = prev | ({{(N_EXP-1){1'b0}}, ~term} << e);
   end

   assign exp_o = g_e[N_EXP-1].nxt;

endmodule

// File: rtl/sxf_macrocell_out.sv
module sxf_macrocell_out
   import sxf_pkg::*;
#(
   parameter int N_SUM = 3,
   localparam int N_PT = N_SUM + N_SEC
) (
   input  logic [N_PT-1:0] pt_i,
   output mc_out_t         out_o
);

   logic sum;

   if (N_SUM == 1) begin : g_single
      assign sum = pt_i[0];
   end else begin : g_multi
      assign sum = |pt_i[N_SUM-1:0];
   end

   always_comb begin
      out_o.fn  = sum ^ pt_i[N_SUM + SLOT_POL];
      out_o.pre = pt_i[N_SUM + SLOT_PRE];
      out_o.clr = pt_i[N_SUM + SLOT_CLR];
      out_o.clk = pt_i[N_SUM + SLOT_CLK];
      out_o.oe  = pt_i[N_SUM + SLOT_OE];
   end

endmodule

// File: rtl/shared_expander_fabric.sv
module shared_expander_fabric
   import sxf_pkg::*;
#(
   parameter int N_DED = 4,
   parameter int N_PIA = 6,
   parameter int N_MC  = 4,
   parameter int N_IO  = 4,
   parameter int N_EXP = 8,
   parameter int N_SUM = 3,
   localparam int N_ARR = N_DED + N_PIA + N_MC + N_IO,
   localparam int N_PT  = N_SUM + N_SEC
) (
   input  logic [N_DED-1:0]            ded_i,
   input  logic [N_PIA-1:0]            pia_i,
   input  logic [N_MC-1:0]             mc_fb_i,
   input  logic [N_IO-1:0]             io_fb_i,
   input  logic [N_EXP*N_ARR-1:0]      exp_sel_t_i,
   input  logic [N_EXP*N_ARR-1:0]      exp_sel_c_i,
   input  logic [N_EXP*N_EXP-1:0]      exp_chain_t_i,
   input  logic [N_EXP*N_EXP-1:0]      exp_chain_c_i,
   input  logic [N_MC*N_PT*N_ARR-1:0]  pt_sel_t_i,
   input  logic [N_MC*N_PT*N_ARR-1:0]  pt_sel_c_i,
   input  logic [N_MC*N_PT*N_EXP-1:0]  pt_exp_t_i,
   input  logic [N_MC*N_PT*N_EXP-1:0]  pt_exp_c_i,
   output logic [N_MC-1:0]             mc_fn_o,
   output logic [N_MC-1:0]             mc_pre_o,
   output logic [N_MC-1:0]             mc_clr_o,
   output logic [N_MC-1:0]             mc_clk_o,
   output logic [N_MC-1:0]             mc_oe_o
);

   initial begin
      assert (N_DED >= 1 && N_PIA >= 1 && N_MC >= 1 && N_IO >= 1)
         else $error("shared_expander_fabric: every input group needs at least one bit");
      assert (N_EXP >= 1) else $error("shared_expander_fabric: N_EXP must be at least 1");
      assert (N_SUM >= 1) else $error("shared_expander_fabric: N_SUM must be at least 1");
   end

   logic [N_ARR-1:0]     arr_w;
   logic [N_EXP-1:0]     exp_w;
   logic [N_MC*N_PT-1:0] pt_w;

   assign arr_w = {io_fb_i, mc_fb_i, pia_i, ded_i};

   sxf_expander_pool #(.N_ARR(N_ARR), .N_EXP(N_EXP)) u_pool (
      .arr_i     (arr_w),
      .sel_t_i   (exp_sel_t_i),
      .sel_c_i   (exp_sel_c_i),
      .chain_t_i (exp_chain_t_i),
      .chain_c_i (exp_chain_c_i),
      .exp_o     (exp_w)
   );

   for (genvar m = 0; m < N_MC; m++) begin : g_mc
      mc_out_t res;

      for (genvar k = 0; k < N_PT; k++) begin : g_pt
         localparam int IDX = m*N_PT + k;
         sxf_product_term #(.W_ARR(N_ARR), .W_EXP(N_EXP)) u_term (
            .arr_i    (arr_w),
            .exp_i    (exp_w),
            .sel_at_i (pt_sel_t_i[IDX*N_ARR +: N_ARR]),
            .sel_ac_i (pt_sel_c_i[IDX*N_ARR +: N_ARR]),
            .sel_et_i (pt_exp_t_i[IDX*N_EXP +: N_EXP]),
            .sel_ec_i (pt_exp_c_i[IDX*N_EXP +: N_EXP]),
            .term_o   (pt_w[IDX])
         );
      end

      sxf_macrocell_out #(.N_SUM(N_SUM)) u_out (
         .pt_i  (pt_w[m*N_PT +: N_PT]),
         .out_o (res)
      );

      assign mc_fn_o[m]  = res.fn;
      assign mc_pre_o[m] = res.pre;
      assign mc_clr_o[m] = res.clr;
      assign mc_clk_o[m] = res.clk;
      assign mc_oe_o[m]  = res.oe;
   end

endmodule

// File: rtl/sxf_fabric_chk.sv
module sxf_fabric_chk #(
   parameter int N_ARR = 4,
   parameter int N_EXP = 4,
   parameter int N_MC  = 4,
   parameter int N_SUM = 3,
   parameter int N_PT  = 8
) (
   input logic [N_EXP*N_ARR-1:0]     exp_sel_t_i,
   input logic [N_EXP*N_ARR-1:0]     exp_sel_c_i,
   input logic [N_EXP*N_EXP-1:0]     exp_chain_t_i,
   input logic [N_EXP*N_EXP-1:0]     exp_chain_c_i,
   input logic [N_MC*N_PT*N_ARR-1:0] pt_sel_t_i,
   input logic [N_MC*N_PT*N_ARR-1:0] pt_sel_c_i,
   input logic [N_MC*N_PT*N_EXP-1:0] pt_exp_t_i,
   input logic [N_MC*N_PT*N_EXP-1:0] pt_exp_c_i,
   input logic [N_EXP-1:0]           exp_w,
   input logic [N_MC*N_PT-1:0]       pt_w,
   input logic [N_MC-1:0]            mc_fn_o,
   input logic [N_MC-1:0]            mc_oe_o
);

   always_comb begin
      for (int e = 0; e < N_EXP; e++) begin
         logic empty_e;
         logic clash_e;
         empty_e = ~(|exp_sel_t_i[e*N_ARR +: N_ARR]) & ~(|exp_sel_c_i[e*N_ARR +: N_ARR]);
         for (int j = 0; j < e; j++) begin
            if (exp_chain_t_i[e*N_EXP+j] || exp_chain_c_i[e*N_EXP+j]) empty_e = 1'b0;
         end
         clash_e = |(exp_sel_t_i[e*N_ARR +: N_ARR] & exp_sel_c_i[e*N_ARR +: N_ARR]);
         // R1, R2: only lower-numbered chain selects make an expander non-empty
         assert_exp_idle_R1: assert (!empty_e || exp_w[e])
            else $error("expander %0d idle but low", e);
         assert_exp_clash_R7: assert (!clash_e || exp_w[e])
            else $error("expander %0d contradictory but low", e);
      end
      for (int t = 0; t < N_MC*N_PT; t++) begin
         logic empty_t;
         logic clash_t;
         empty_t = ~(|pt_sel_t_i[t*N_ARR +: N_ARR]) & ~(|pt_sel_c_i[t*N_ARR +: N_ARR])
                 & ~(|pt_exp_t_i[t*N_EXP +: N_EXP]) & ~(|pt_exp_c_i[t*N_EXP +: N_EXP]);
         clash_t = |(pt_sel_t_i[t*N_ARR +: N_ARR] & pt_sel_c_i[t*N_ARR +: N_ARR])
                 | |(pt_exp_t_i[t*N_EXP +: N_EXP] & pt_exp_c_i[t*N_EXP +: N_EXP]);
         assert_pt_idle_R3: assert (!empty_t || !pt_w[t])
            else $error("term %0d empty but high", t);
         assert_pt_clash_R7: assert (!clash_t || !pt_w[t])
            else $error("term %0d contradictory but high", t);
      end
      for (int m = 0; m < N_MC; m++) begin
         assert_fn_quiet_R4: assert ((|pt_w[m*N_PT +: N_SUM+1]) || !mc_fn_o[m])
            else $error("macrocell %0d logic high with all sum and polarity terms low", m);
         assert_oe_term_R5: assert (pt_w[m*N_PT + N_SUM + 4] == mc_oe_o[m])
            else $error("macrocell %0d enable differs from its slot", m);
      end
   end

endmodule

bind shared_expander_fabric sxf_fabric_chk #(
   .N_ARR(N_ARR), .N_EXP(N_EXP), .N_MC(N_MC), .N_SUM(N_SUM), .N_PT(N_PT)
) u_chk (
   .exp_sel_t_i   (exp_sel_t_i),
   .exp_sel_c_i   (exp_sel_c_i),
   .exp_chain_t_i (exp_chain_t_i),
   .exp_chain_c_i (exp_chain_c_i),
   .pt_sel_t_i    (pt_sel_t_i),
   .pt_sel_c_i    (pt_sel_c_i),
   .pt_exp_t_i    (pt_exp_t_i),
   .pt_exp_c_i    (pt_exp_c_i),
   .exp_w         (exp_w),
   .pt_w          (pt_w),
   .mc_fn_o       (mc_fn_o),
   .mc_oe_o       (mc_oe_o)
);

// File: tb/shared_expander_fabric_tb.sv
module shared_expander_fabric_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N_DED = 4, N_PIA = 6, N_MC = 4, N_IO = 4, N_EXP = 8, N_SUM = 3;
   localparam int N_ARR = N_DED + N_PIA + N_MC + N_IO;
   localparam int N_PT  = N_SUM + 5;
   localparam int S_POL = N_SUM, S_PRE = N_SUM+1, S_CLR = N_SUM+2, S_CLK = N_SUM+3, S_OE = N_SUM+4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   logic [N_DED-1:0] ded;
   logic [N_PIA-1:0] pia;
   logic [N_MC-1:0]  mcfb;
   logic [N_IO-1:0]  iofb;
   logic [N_EXP*N_ARR-1:0]     e_at, e_ac;
   logic [N_EXP*N_EXP-1:0]     e_ct, e_cc;
   logic [N_MC*N_PT*N_ARR-1:0] p_at, p_ac;
   logic [N_MC*N_PT*N_EXP-1:0] p_et, p_ec;
   logic [N_MC-1:0] fn, pre, clr, ck, oe;
   logic [N_MC-1:0] r_fn, r_pre, r_clr, r_ck, r_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   shared_expander_fabric #(
      .N_DED(N_DED), .N_PIA(N_PIA), .N_MC(N_MC), .N_IO(N_IO), .N_EXP(N_EXP), .N_SUM(N_SUM)
   ) u_dut (
      .ded_i(ded), .pia_i(pia), .mc_fb_i(mcfb), .io_fb_i(iofb),
      .exp_sel_t_i(e_at), .exp_sel_c_i(e_ac), .exp_chain_t_i(e_ct), .exp_chain_c_i(e_cc),
      .pt_sel_t_i(p_at), .pt_sel_c_i(p_ac), .pt_exp_t_i(p_et), .pt_exp_c_i(p_ec),
      .mc_fn_o(fn), .mc_pre_o(pre), .mc_clr_o(clr), .mc_clk_o(ck), .mc_oe_o(oe)
   );

   task automatic chk(string tag, logic [N_MC-1:0] got, logic [N_MC-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   // Behavioural reference built from R1..R9
   task automatic ref_eval();
      logic [N_ARR-1:0] a;
      logic [N_EXP-1:0] x;
      logic [N_PT-1:0]  t;
      a = {iofb, mcfb, pia, ded};
      x = '0;
      for (int e = 0; e < N_EXP; e++) begin
         bit used = 0, hit = 1;
         for (int i = 0; i < N_ARR; i++) begin
            if (e_at[e*N_ARR+i]) begin used = 1; if (!a[i]) hit = 0; end
            if (e_ac[e*N_ARR+i]) begin used = 1; if (a[i])  hit = 0; end
         end
         for (int j = 0; j < e; j++) begin
            if (e_ct[e*N_EXP+j]) begin used = 1; if (!x[j]) hit = 0; end
            if (e_cc[e*N_EXP+j]) begin used = 1; if (x[j])  hit = 0; end
         end
         x[e] = !(used && hit);
      end
      for (int m = 0; m < N_MC; m++) begin
         int nsum = 0;
         for (int k = 0; k < N_PT; k++) begin
            int b = m*N_PT + k;
            bit used = 0, hit = 1;
            for (int i = 0; i < N_ARR; i++) begin
               if (p_at[b*N_ARR+i]) begin used = 1; if (!a[i]) hit = 0; end
               if (p_ac[b*N_ARR+i]) begin used = 1; if (a[i])  hit = 0; end
            end
            for (int j = 0; j < N_EXP; j++) begin
               if (p_et[b*N_EXP+j]) begin used = 1; if (!x[j]) hit = 0; end
               if (p_ec[b*N_EXP+j]) begin used = 1; if (x[j])  hit = 0; end
            end
            t[k] = used && hit;
            if (k < N_SUM && t[k]) nsum++;
         end
         r_fn[m]  = (nsum > 0) != t[S_POL];
         r_pre[m] = t[S_PRE];
         r_clr[m] = t[S_CLR];
         r_ck[m]  = t[S_CLK];
         r_oe[m]  = t[S_OE];
      end
   endtask

   task automatic compare_all();
      ref_eval();
      chk("R4 fn", fn, r_fn);
      chk("R5 pre", pre, r_pre);
      chk("R5 clr", clr, r_clr);
      chk("R5 clk", ck, r_ck);
      chk("R5 oe", oe, r_oe);
   endtask

   task automatic clear_cfg();
      e_at = '0; e_ac = '0; e_ct = '0; e_cc = '0;
      p_at = '0; p_ac = '0; p_et = '0; p_ec = '0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      ded = '0; pia = '0; mcfb = '0; iofb = '0;
      clear_cfg();
      repeat (3) @(posedge clk);
      rst = 1'b0;
      settle();
      // Reset-state: empty configuration gives all zero (R3)
      chk("R3 idle fn", fn, '0);
      chk("R3 idle oe", oe, '0);
      compare_all();

      // R1: empty expander 0 reads as 1 through slot 0 of macrocell 0 (R9)
      p_et[(0*N_PT+0)*N_EXP+0] = 1'b1;
      settle();
      chk("R1 idle expander", fn, 4'b0001);
      // R1, R8: expander 0 = NAND(ded[0]); ded bit 0 is array bit 0
      e_at[0*N_ARR+0] = 1'b1;
      ded = 4'b0001; settle();
      chk("R1 nand high input", fn, 4'b0000);
      ded = 4'b0000; settle();
      chk("R1 nand low input", fn, 4'b0001);
      compare_all();

      // R2: expander 1 chains expander 0 in true form; slot 0 now uses expander 1
      p_et[(0*N_PT+0)*N_EXP+0] = 1'b0;
      p_et[(0*N_PT+0)*N_EXP+1] = 1'b1;
      e_ct[1*N_EXP+0] = 1'b1;
      ded = 4'b0001; settle();
      chk("R2 cascade", fn, 4'b0001);
      // R2: a forward select from expander 0 to expander 1 is ignored
      e_ct[0*N_EXP+1] = 1'b1;
      e_cc[0*N_EXP+3] = 1'b1;
      settle();
      chk("R2 forward select ignored", fn, 4'b0001);
      ded = 4'b0000; settle();
      chk("R2 forward select ignored low", fn, 4'b0000);
      compare_all();

      // R6: expander 1 shared by every preset slot and by slot 1 of macrocell 0
      for (int m = 0; m < N_MC; m++) p_et[(m*N_PT+S_PRE)*N_EXP+1] = 1'b1;
      p_et[(0*N_PT+1)*N_EXP+1] = 1'b1;
      ded = 4'b0001; settle();
      chk("R6 shared preset", pre, 4'b1111);
      chk("R6 shared sum", fn, 4'b0001);
      ded = 4'b0000; settle();
      chk("R6 shared preset low", pre, 4'b0000);
      compare_all();

      // R8, R9: clock slot of macrocell 2 takes pia[0] (array bit N_DED)
      clear_cfg();
      p_at[(2*N_PT+S_CLK)*N_ARR+N_DED] = 1'b1;
      // enable slot of macrocell 3 takes complement of mc_fb[3]
      p_ac[(3*N_PT+S_OE)*N_ARR+N_DED+N_PIA+3] = 1'b1;
      pia = 6'b000001; mcfb = 4'b0000; settle();
      chk("R9 clock slot", ck, 4'b0100);
      chk("R5 enable slot", oe, 4'b1000);
      mcfb = 4'b1000; settle();
      chk("R5 enable follows feedback", oe, 4'b0000);

      // R4: polarity slot of macrocell 1 takes io_fb[1]; then a sum term with the same literal
      p_at[(1*N_PT+S_POL)*N_ARR+N_DED+N_PIA+N_MC+1] = 1'b1;
      iofb = 4'b0010; settle();
      chk("R4 polarity only", fn, 4'b0010);
      p_at[(1*N_PT+2)*N_ARR+N_DED+N_PIA+N_MC+1] = 1'b1;
      settle();
      chk("R4 polarity cancels sum", fn, 4'b0000);

      // R7: clear slot of macrocell 2 takes ded[1] in both forms
      p_at[(2*N_PT+S_CLR)*N_ARR+1] = 1'b1;
      p_ac[(2*N_PT+S_CLR)*N_ARR+1] = 1'b1;
      ded = 4'b0010; settle();
      chk("R7 contradictory term", clr, 4'b0000);
      ded = 4'b0000; settle();
      chk("R7 contradictory term low", clr, 4'b0000);
      compare_all();

      // Random configurations and inputs, reference compared every clock
      for (int c = 0; c < 600; c++) begin
         @(posedge clk); #1;
         if (c % 20 == 0) begin
            for (int b = 0; b < N_EXP*N_ARR; b++) begin
               e_at[b] = ($urandom % 10) == 0; e_ac[b] = ($urandom % 12) == 0;
            end
            for (int b = 0; b < N_EXP*N_EXP; b++) begin
               e_ct[b] = ($urandom % 5) == 0; e_cc[b] = ($urandom % 6) == 0;
            end
            for (int b = 0; b < N_MC*N_PT*N_ARR; b++) begin
               p_at[b] = ($urandom % 14) == 0; p_ac[b] = ($urandom % 16) == 0;
            end
            for (int b = 0; b < N_MC*N_PT*N_EXP; b++) begin
               p_et[b] = ($urandom % 6) == 0; p_ec[b] = ($urandom % 8) == 0;
            end
         end
         ded  = N_DED'($urandom);
         pia  = N_PIA'($urandom);
         mcfb = N_MC'($urandom);
         iofb = N_IO'($urandom);
         settle();
         compare_all();
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule